// File: doc/BRIEF.md
# Interrupt-Driven OS Service Dispatcher

This block turns selected peripheral interrupt lines into kernel service operations with no processor code involved. A small table, loaded while the block is held out of operation, binds an interrupt line to an action (post an event flag, signal a semaphore, release a task from a wait, or wake a task) and to the object number the action targets. When a bound line rises, the block hands a service request to the kernel object logic and waits for that logic to report completion.

The processor interrupt is raised only afterwards, and only where it is needed. It is raised when the table entry says a software handler also exists, or when the object logic reports that the action readied a task that must preempt the running one. Lines with no enabled table entry are forwarded untouched to the processor pending set. The running task is therefore not disturbed while the hardware action runs, unless that action ends in a task switch.

Top module: `irq_service_table`

## Requirements
- R1: After reset, `svc_valid_o`, `cpu_irq_o` and `cpu_switch_o` are low and `cpu_pend_o` is all zero.
- R2: A table write (`cfg_we_i`) takes effect only while `run_i` is low. A write while `run_i` is high leaves the entry unchanged, and a later interrupt on that line still issues the old action and object.
- R3: With `run_i` high, a rising edge on a line bound by an enabled entry issues exactly one request carrying that entry's action code and object number. Action codes are 0 = post flag, 1 = signal semaphore, 2 = release wait, 3 = wake task.
- R4: A request stays asserted with stable action and object until `svc_done_i` is seen. It drops in the following cycle, and at most one request is outstanding.
- R5: When several bound lines are pending, they are served one at a time in order of increasing line index.
- R6: Further rising edges on a line whose request has not yet completed are merged into the one pending request.
- R7: For an entry with its handler flag set, `cpu_pend_o` for that line is set only in the cycle after completion, never before it. An entry without the flag leaves `cpu_pend_o` unchanged.
- R8: A completion with `svc_switch_i` high sets `cpu_switch_o`, which holds until `switch_ack_i`. A completion with `svc_switch_i` low leaves it low.
- R9: A rising edge on a line with no enabled entry sets that line's `cpu_pend_o` bit in the next cycle and issues no request.
- R10: Interrupt edges that occur while `run_i` is low are discarded. They cause neither a request nor a pending bit.
- R11: `cpu_clr_i` clears the matching `cpu_pend_o` bits, and `cpu_irq_o` is high exactly when any `cpu_pend_o` bit or `cpu_switch_o` is high.
- R12: An entry written with its enable bit low makes its line behave as unbound (R9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High: service interrupts; low: table may be loaded |
| irq_i | input | NUM_IRQ | Raw interrupt lines, rising edge active |
| cfg_we_i | input | 1 | Table entry write strobe |
| cfg_idx_i | input | log2(NUM_ENTRY) | Entry index to write |
| cfg_en_i | input | 1 | Entry enable |
| cfg_src_i | input | log2(NUM_IRQ) | Interrupt line bound to the entry |
| cfg_act_i | input | 2 | Action code |
| cfg_obj_i | input | OBJ_W | Target object number |
| cfg_sw_i | input | 1 | Software handler registered for the line |
| svc_valid_o | output | 1 | Service request valid |
| svc_act_o | output | 2 | Requested action code |
| svc_obj_o | output | OBJ_W | Requested object number |
| svc_done_i | input | 1 | Object logic finished the request |
| svc_switch_i | input | 1 | Finished action requires a task switch |
| cpu_irq_o | output | 1 | Processor interrupt request |
| cpu_pend_o | output | NUM_IRQ | Lines awaiting a software handler |
| cpu_clr_i | input | NUM_IRQ | Write-one-to-clear for cpu_pend_o |
| cpu_switch_o | output | 1 | Task switch required |
| switch_ack_i | input | 1 | Clears cpu_switch_o |

## Verification
Several properties are checked on every cycle: that a request holds steady until completion and then drops, that no new request starts while the block is halted, that the switch flag rises only from a completion that reported a switch, that the processor interrupt never rises ahead of a hardware completion or a pass-through edge, that the table is frozen while running, and that a pending line is never lost before it is served. The bench scenarios cover the rest. They show that each line maps to the right action code and object number, that service follows line order, that repeated edges merge, that unbound and disabled lines pass through, and that edges arriving during load are dropped.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;
  typedef enum logic [1:0] {
    SVC_SET_FLAG = 2'd0,
    SVC_SIG_SEM  = 2'd1,
    SVC_REL_WAIT = 2'd2,
    SVC_WAKE     = 2'd3
  } svc_op_e;
endpackage

// File: rtl/irq_svc_edge.sv
module irq_svc_edge #(
  parameter int NUM_IRQ = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] bound_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  output logic [NUM_IRQ-1:0] edge_o,
  output logic [NUM_IRQ-1:0] pend_o
);
  logic [NUM_IRQ-1:0] irq_q, pend_q;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign edge_o[g] = irq_i[g] & ~irq_q[g] & run_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_q[g]  <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        irq_q[g]  <= irq_i[g];
        // set wins: an edge in the completion cycle is a new request
        pend_q[g] <= (pend_q[g] & ~clr_i[g]) | (edge_o[g] & bound_i[g]);
      end
    end
  end

  assign pend_o = pend_q;

  assert_pend_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o != '0) && ((pend_o & clr_i) == '0) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: rtl/irq_svc_map.sv
module irq_svc_map
  import irq_svc_pkg::*;
#(
  parameter int NUM_IRQ   = 128,
  parameter int NUM_ENTRY = 32,
  parameter int OBJ_W     = 8,
  localparam int SRC_W    = $clog2(NUM_IRQ),
  localparam int IDX_W    = $clog2(NUM_ENTRY)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic               cfg_en_i,
  input  logic [SRC_W-1:0]   cfg_src_i,
  input  svc_op_e            cfg_act_i,
  input  logic [OBJ_W-1:0]   cfg_obj_i,
  input  logic               cfg_sw_i,
  input  logic [SRC_W-1:0]   look_src_i,
  output logic [NUM_IRQ-1:0] bound_o,
  output logic               hit_o,
  output svc_op_e            act_o,
  output logic [OBJ_W-1:0]   obj_o,
  output logic               sw_o
);
  logic [NUM_ENTRY-1:0]             en_q, sw_q;
  logic [NUM_ENTRY-1:0][SRC_W-1:0]  src_q;
  logic [NUM_ENTRY-1:0][OBJ_W-1:0]  obj_q;
  svc_op_e [NUM_ENTRY-1:0]          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      sw_q  <= '0;
      src_q <= '0;
      obj_q <= '0;
      for (int e = 0; e < NUM_ENTRY; e++) act_q[e] <= SVC_SET_FLAG;
    end else if (cfg_we_i && !run_i && (int'(cfg_idx_i) < NUM_ENTRY)) begin
      en_q[cfg_idx_i]  <= cfg_en_i;
      sw_q[cfg_idx_i]  <= cfg_sw_i;
      src_q[cfg_idx_i] <= cfg_src_i;
      obj_q[cfg_idx_i] <= cfg_obj_i;
      act_q[cfg_idx_i] <= cfg_act_i;
    end
  end

  always_comb begin
    bound_o = '0;
    for (int e = 0; e < NUM_ENTRY; e++)
      if (en_q[e]) bound_o[src_q[e]] = 1'b1;
  end

  // lowest entry wins if a line is bound twice
  always_comb begin
    hit_o = 1'b0;
    act_o = SVC_SET_FLAG;
    obj_o = '0;
    sw_o  = 1'b0;
    for (int e = NUM_ENTRY - 1; e >= 0; e--) begin
      if (en_q[e] && (src_q[e] == look_src_i)) begin
        hit_o = 1'b1;
        act_o = act_q[e];
        obj_o = obj_q[e];
        sw_o  = sw_q[e];
      end
    end
  end

  assert_table_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> $stable(en_q) && $stable(src_q) && $stable(obj_q) && $stable(sw_q));
endmodule

// File: rtl/irq_svc_pick.sv
module irq_svc_pick #(
  parameter int N    = 128,
  localparam int W   = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req_i[i]) idx_o = W'(i);
  end
endmodule

// File: rtl/irq_service_table.sv
module irq_service_table
  import irq_svc_pkg::*;
#(
  parameter int NUM_IRQ   = 128,
  parameter int NUM_ENTRY = 32,
  parameter int OBJ_W     = 8,
  localparam int SRC_W    = $clog2(NUM_IRQ),
  localparam int IDX_W    = $clog2(NUM_ENTRY)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic               cfg_en_i,
  input  logic [SRC_W-1:0]   cfg_src_i,
  input  logic [1:0]         cfg_act_i,
  input  logic [OBJ_W-1:0]   cfg_obj_i,
  input  logic               cfg_sw_i,
  output logic               svc_valid_o,
  output logic [1:0]         svc_act_o,
  output logic [OBJ_W-1:0]   svc_obj_o,
  input  logic               svc_done_i,
  input  logic               svc_switch_i,
  output logic               cpu_irq_o,
  output logic [NUM_IRQ-1:0] cpu_pend_o,
  input  logic [NUM_IRQ-1:0] cpu_clr_i,
  output logic               cpu_switch_o,
  input  logic               switch_ack_i
);
  logic [NUM_IRQ-1:0] bound, edges, hw_pend, hw_clr, cpu_pend_q;
  logic               any, hit, look_sw, fire, start, stale;
  logic [SRC_W-1:0]   pick;
  svc_op_e            look_act;
  logic [OBJ_W-1:0]   look_obj;

  logic               valid_q, sw_q, switch_q;
  logic [SRC_W-1:0]   src_q;
  svc_op_e            act_q;
  logic [OBJ_W-1:0]   obj_q;

  irq_svc_edge #(.NUM_IRQ(NUM_IRQ)) u_edge (
    .clk_i, .rst_ni, .run_i, .irq_i,
    .bound_i(bound), .clr_i(hw_clr), .edge_o(edges), .pend_o(hw_pend)
  );

  irq_svc_pick #(.N(NUM_IRQ)) u_pick (
    .req_i(hw_pend), .any_o(any), .idx_o(pick)
  );

  irq_svc_map #(.NUM_IRQ(NUM_IRQ), .NUM_ENTRY(NUM_ENTRY), .OBJ_W(OBJ_W)) u_map (
    .clk_i, .rst_ni, .run_i, .cfg_we_i, .cfg_idx_i, .cfg_en_i, .cfg_src_i,
    .cfg_act_i(svc_op_e'(cfg_act_i)), .cfg_obj_i, .cfg_sw_i,
    .look_src_i(pick), .bound_o(bound), .hit_o(hit),
    .act_o(look_act), .obj_o(look_obj), .sw_o(look_sw)
  );

  assign fire  = valid_q & svc_done_i;
  assign start = !valid_q && run_i && any && hit;
  assign stale = !valid_q && run_i && any && !hit;

  always_comb begin
    hw_clr = '0;
    if (fire)       hw_clr[src_q] = 1'b1;
    else if (stale) hw_clr[pick]  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      sw_q    <= 1'b0;
      src_q   <= '0;
      act_q   <= SVC_SET_FLAG;
      obj_q   <= '0;
    end else if (fire) begin
      valid_q <= 1'b0;
    end else if (start) begin
      valid_q <= 1'b1;
      sw_q    <= look_sw;
      src_q   <= pick;
      act_q   <= look_act;
      obj_q   <= look_obj;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_pend_q <= '0;
      switch_q   <= 1'b0;
    end else begin
      cpu_pend_q <= (cpu_pend_q & ~cpu_clr_i) | (edges & ~bound);
      if (fire && sw_q) cpu_pend_q[src_q] <= 1'b1;
      if (fire && svc_switch_i) switch_q <= 1'b1;
      else if (switch_ack_i)    switch_q <= 1'b0;
    end
  end

  assign svc_valid_o  = valid_q;
  assign svc_act_o    = act_q;
  assign svc_obj_o    = obj_q;
  assign cpu_pend_o   = cpu_pend_q;
  assign cpu_switch_o = switch_q;
  assign cpu_irq_o    = (|cpu_pend_q) | switch_q;

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_valid_o && !svc_done_i |=> svc_valid_o && $stable(svc_obj_o) && $stable(svc_act_o));

  assert_single_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_valid_o && svc_done_i |=> !svc_valid_o);

  assert_halt_no_issue_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !svc_valid_o |=> !svc_valid_o);

  assert_switch_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_switch_o) |-> $past(svc_valid_o && svc_done_i && svc_switch_i));

  assert_hw_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_irq_o) |-> $past((svc_valid_o && svc_done_i) || ((edges & ~bound) != '0)));
endmodule

// File: tb/irq_service_table_bench.sv
`timescale 1ns/1ps
module irq_service_table_bench;
  localparam int NI = 128;
  localparam int NE = 32;
  localparam int OW = 8;

  typedef struct packed {
    logic [6:0] src;
    logic [1:0] act;
    logic [7:0] obj;
    logic       sw_resp;
    logic       exp_cpu;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{7'd5,   2'd0, 8'h11, 1'b0, 1'b0},
    '{7'd40,  2'd1, 8'h22, 1'b0, 1'b1},
    '{7'd77,  2'd2, 8'h33, 1'b1, 1'b0},
    '{7'd127, 2'd3, 8'h44, 1'b1, 1'b1},
    '{7'd3,   2'd1, 8'h55, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic [NI-1:0] irq = '0, cpu_clr = '0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_sw = 1'b0;
  logic [4:0] cfg_idx = '0;
  logic [6:0] cfg_src = '0;
  logic [1:0] cfg_act = '0;
  logic [OW-1:0] cfg_obj = '0;
  logic svc_done = 1'b0, svc_switch = 1'b0, switch_ack = 1'b0;
  logic svc_valid, cpu_irq, cpu_switch;
  logic [1:0] svc_act;
  logic [OW-1:0] svc_obj;
  logic [NI-1:0] cpu_pend;
  int n_tot = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_service_table #(.NUM_IRQ(NI), .NUM_ENTRY(NE), .OBJ_W(OW)) u_irq_service_table (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .irq_i(irq),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_en_i(cfg_en), .cfg_src_i(cfg_src),
    .cfg_act_i(cfg_act), .cfg_obj_i(cfg_obj), .cfg_sw_i(cfg_sw),
    .svc_valid_o(svc_valid), .svc_act_o(svc_act), .svc_obj_o(svc_obj),
    .svc_done_i(svc_done), .svc_switch_i(svc_switch),
    .cpu_irq_o(cpu_irq), .cpu_pend_o(cpu_pend), .cpu_clr_i(cpu_clr),
    .cpu_switch_o(cpu_switch), .switch_ack_i(switch_ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cfg_write(input int idx, input logic en, input int src,
                           input logic [1:0] act, input logic [7:0] obj, input logic sw);
    tick();
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_en = en; cfg_src = 7'(src);
    cfg_act = act; cfg_obj = obj; cfg_sw = sw;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [NI-1:0] mask);
    tick();
    irq = mask;
    tick();
    irq = '0;
  endtask

  task automatic wait_req(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (svc_valid) begin ok = 1'b1; break; end
      tick();
    end
  endtask

  task automatic serve(input logic sw);
    svc_done = 1'b1; svc_switch = sw;
    tick();
    svc_done = 1'b0; svc_switch = 1'b0;
  endtask

  task automatic clear_all();
    cpu_clr = '1; switch_ack = 1'b1;
    tick();
    cpu_clr = '0; switch_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tot++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    logic ok;
    logic [NI-1:0] m;
    int extra;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 svc_valid", svc_valid, 0);
    chk("R1 cpu_irq", cpu_irq, 0);
    chk("R1 cpu_pend", (cpu_pend != '0), 0);
    chk("R1 cpu_switch", cpu_switch, 0);

    cfg_write(0, 1'b1, 5,   2'd0, 8'h11, 1'b0);
    cfg_write(1, 1'b1, 40,  2'd1, 8'h22, 1'b1);
    cfg_write(2, 1'b1, 77,  2'd2, 8'h33, 1'b0);
    cfg_write(3, 1'b1, 127, 2'd3, 8'h44, 1'b1);
    cfg_write(4, 1'b1, 3,   2'd1, 8'h55, 1'b0);
    cfg_write(5, 1'b0, 90,  2'd3, 8'h66, 1'b1);  // R12 disabled
    run = 1'b1;

    foreach (VECS[v]) begin
      m = '0; m[VECS[v].src] = 1'b1;
      pulse(m);
      wait_req(ok);
      chk("R3 request issued", ok, 1);
      chk("R3 action code", svc_act, VECS[v].act);
      chk("R3 object", svc_obj, VECS[v].obj);
      repeat (2) tick();
      chk("R4 held until done", svc_valid, 1);
      chk("R4 object stable", svc_obj, VECS[v].obj);
      chk("R7 no cpu pend before done", cpu_pend[VECS[v].src], 0);
      serve(VECS[v].sw_resp);
      chk("R4 dropped after done", svc_valid, 0);
      chk("R7 cpu pend after done", cpu_pend[VECS[v].src], VECS[v].exp_cpu);
      chk("R8 switch flag", cpu_switch, VECS[v].sw_resp);
      chk("R11 cpu_irq", cpu_irq, VECS[v].exp_cpu | VECS[v].sw_resp);
      clear_all();
      chk("R11 cleared", cpu_irq, 0);
    end

    // R5 ordering
    m = '0; m[77] = 1'b1; m[5] = 1'b1; m[40] = 1'b1;
    pulse(m);
    wait_req(ok); chk("R5 first obj", svc_obj, 8'h11); serve(1'b0);
    wait_req(ok); chk("R5 second obj", svc_obj, 8'h22); serve(1'b0);
    wait_req(ok); chk("R5 third obj", svc_obj, 8'h33); serve(1'b0);
    chk("R7 pend only for flagged line", cpu_pend, {{(NI-41){1'b0}}, 1'b1, 40'b0});
    clear_all();

    // R6 merge
    m = '0; m[5] = 1'b1;
    pulse(m);
    wait_req(ok);
    pulse(m);
    pulse(m);
    serve(1'b0);
    extra = 0;
    for (int i = 0; i < 10; i++) begin
      if (svc_valid) extra++;
      tick();
    end
    chk("R6 merged edges", extra, 0);

    // R9 / R12 pass-through
    m = '0; m[60] = 1'b1;
    pulse(m);
    chk("R9 unbound pend", cpu_pend[60], 1);
    chk("R9 cpu_irq", cpu_irq, 1);
    m = '0; m[90] = 1'b1;
    pulse(m);
    chk("R12 disabled entry pend", cpu_pend[90], 1);
    extra = 0;
    for (int i = 0; i < 5; i++) begin
      if (svc_valid) extra++;
      tick();
    end
    chk("R9 no request", extra, 0);
    clear_all();

    // R10 halted
    run = 1'b0;
    m = '0; m[5] = 1'b1; m[60] = 1'b1;
    pulse(m);
    repeat (4) tick();
    chk("R10 no request halted", svc_valid, 0);
    chk("R10 no cpu pend halted", cpu_irq, 0);
    run = 1'b1;
    repeat (5) tick();
    chk("R10 no late request", svc_valid, 0);

    // R2 frozen table
    cfg_write(0, 1'b1, 5, 2'd3, 8'h99, 1'b1);
    m = '0; m[5] = 1'b1;
    pulse(m);
    wait_req(ok);
    chk("R2 object unchanged", svc_obj, 8'h11);
    chk("R2 action unchanged", svc_act, 2'd0);
    serve(1'b0);
    chk("R2 handler flag unchanged", cpu_pend[5], 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule